// File: doc/BRIEF.md
# USB Host Port Reset and Enable Controller

This block runs the reset and enable side of one USB 2.0 host port. Software writes a reset bit and an enable bit. The block also takes the port power and connect status, a controller-halted flag, the sampled D+ and D- line levels, the speed reported by the PHY, and a reset-finished indication from the PHY. From these it drives a bus-reset request to the PHY, reports the bus line levels for low-speed detection, and holds the port-enable and reset-status bits that software reads back.

A reset goes through three states:

- **ST_IDLE**: no reset is in progress.
- **ST_DRIVE**: the bus reset is being driven.
- **ST_TERM**: software has released the reset bit, but the PHY has not yet reported that the reset is done.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_START | ST_IDLE | ST_DRIVE | Software writes 1 to the reset bit while the port is powered. |
| T_RELEASE | ST_DRIVE | ST_TERM | Software writes 0 to the reset bit while the controller is not halted. |
| T_DONE | ST_TERM | ST_IDLE | The PHY reports that the reset is done. |
| T_EXPIRE | ST_TERM | ST_IDLE | The termination window runs out. |
| T_POWER_OFF | any state | ST_IDLE | Port power drops. |

The reset bit reads 1 in both ST_DRIVE and ST_TERM. The port enables itself only if the device leaves reset in high-speed mode. A device that is not high speed produces a one-cycle full-speed hand-off pulse. A K-state on the lines of a connected, disabled port raises a low-speed hand-off indication.

Top module: `usb_port_rst_ctl`

## Requirements
- R1: After reset, `port_en`, `port_rst`, `phy_bus_rst`, `fs_handoff` and `term_timeout` are all 0.
- R2: While powered, `line_status` equals {D+, D-}, with D+ in bit 1. When unpowered it reads 2'b00. `ls_valid` is 1 exactly when the port is powered, connected and not enabled.
- R3: `ls_handoff` is 1 exactly when `ls_valid` is 1 and `line_status` is 2'b10 (K-state). The codes 2'b00, 2'b01 and 2'b11 give 0.
- R4: A write with `sw_rst_bit`=1 in ST_IDLE on a powered port makes `port_rst` and `phy_bus_rst` 1 and `port_en` 0 from the next cycle.
- R5: A write with `sw_rst_bit`=0 in ST_DRIVE, with `ctl_halted`=0, drops `phy_bus_rst` the next cycle. `port_rst` keeps reading 1 until the reset completes.
- R6: While `ctl_halted`=1, a write of 0 to the reset bit is ignored and the bus reset continues.
- R7: If `phy_rst_done` arrives in ST_TERM with `phy_hs`=1, then from the next cycle `port_en` is 1 and `port_rst` is 0.
- R8: If `phy_rst_done` arrives with `phy_hs`=0, `port_en` stays 0 and `fs_handoff` pulses for exactly one cycle.
- R9: If ST_TERM lasts `CYC_PER_MS*TERM_MS` cycles without `phy_rst_done`, then `term_timeout` becomes 1 and `port_rst` reads 0. `term_timeout` clears on the next reset start. A `phy_rst_done` that arrives in the last cycle of the window counts as a normal completion.
- R10: With `port_power`=0, `port_rst` and `phy_bus_rst` read 0 in the same cycle. From the next cycle the block is in ST_IDLE with `port_en` and `term_timeout` at 0, and writes to the reset bit are ignored.
- R11: A write with `sw_en_bit`=0 in ST_IDLE clears `port_en`. A write with `sw_en_bit`=1 and `sw_rst_bit`=0 never sets it.
- R12: A write of 1 to the reset bit during ST_TERM is ignored: `phy_bus_rst` stays 0 and `port_rst` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe for the port register |
| sw_rst_bit | input | 1 | Value written to the reset bit |
| sw_en_bit | input | 1 | Value written to the enable bit |
| port_power | input | 1 | Port power is on |
| connect | input | 1 | A device is connected |
| ctl_halted | input | 1 | The host controller is halted |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| phy_hs | input | 1 | The PHY found a high-speed device |
| phy_rst_done | input | 1 | The PHY has finished the reset |
| phy_bus_rst | output | 1 | Request to the PHY to drive bus reset |
| port_rst | output | 1 | Reset bit read-back value |
| port_en | output | 1 | Port-enable bit |
| line_status | output | 2 | {D+, D-} line levels |
| ls_valid | output | 1 | `line_status` is meaningful |
| ls_handoff | output | 1 | Low-speed device: release the port to a companion controller |
| fs_handoff | output | 1 | One-cycle pulse: the device is not high speed after reset |
| term_timeout | output | 1 | Reset termination did not finish within the limit |

## Verification
The bench builds the block with `CYC_PER_MS`=4 and `TERM_MS`=2, which shrinks the termination window to 8 cycles. This makes it practical to sweep the delay of the PHY's done signal over every cycle of the window, for both speeds, including the last cycle where completion and expiry coincide. The window can also be left to expire in full. The line-status decode is swept over all combinations of power, connect and the two line levels, both with the port disabled and with it enabled.

// File: rtl/usb_port_rst_pkg.sv
package usb_port_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_TERM  = 2'd2
    } rst_state_e;

    localparam logic [1:0] LINE_K = 2'b10;

endpackage

// File: rtl/usb_line_decode.sv
module usb_line_decode
    import usb_port_rst_pkg::*;
(
    input  logic       power,
    input  logic       connected,
    input  logic       enabled,
    input  logic       dp,
    input  logic       dm,
    output logic [1:0] status,
    output logic       valid,
    output logic       lowspeed
);

    always_comb begin
        status   = power ? {dp, dm} : 2'b00;
        valid    = power && connected && !enabled;
        lowspeed = valid && (status == LINE_K);
    end

endmodule

// File: rtl/usb_term_timer.sv
module usb_term_timer #(
    parameter int CYC_PER_MS = 60000,
    parameter int TERM_MS    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int LIMIT = CYC_PER_MS * TERM_MS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);

endmodule

// File: rtl/usb_port_rst_ctl.sv
module usb_port_rst_ctl
    import usb_port_rst_pkg::*;
#(
    parameter int CYC_PER_MS = 60000,
    parameter int TERM_MS    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic       sw_rst_bit,
    input  logic       sw_en_bit,
    input  logic       port_power,
    input  logic       connect,
    input  logic       ctl_halted,
    input  logic       line_dp,
    input  logic       line_dm,
    input  logic       phy_hs,
    input  logic       phy_rst_done,
    output logic       phy_bus_rst,
    output logic       port_rst,
    output logic       port_en,
    output logic [1:0] line_status,
    output logic       ls_valid,
    output logic       ls_handoff,
    output logic       fs_handoff,
    output logic       term_timeout
);

    rst_state_e state_q, state_d;
    logic       expire;
    logic       t_start, t_release, t_done, t_expire;
    logic       en_d, fs_d, to_d;

    usb_line_decode u_line (
        .power     (port_power),
        .connected (connect),
        .enabled   (port_en),
        .dp        (line_dp),
        .dm        (line_dm),
        .status    (line_status),
        .valid     (ls_valid),
        .lowspeed  (ls_handoff)
    );

    usb_term_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .TERM_MS    (TERM_MS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_TERM),
        .expire (expire)
    );

    // transition conditions
    always_comb begin
        t_start   = port_power && (state_q == ST_IDLE) && sw_wr && sw_rst_bit;
        t_release = port_power && (state_q == ST_DRIVE) && sw_wr && !sw_rst_bit && !ctl_halted;
        t_done    = port_power && (state_q == ST_TERM) && phy_rst_done;
        t_expire  = port_power && (state_q == ST_TERM) && !phy_rst_done && expire;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!port_power) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (t_start)              state_d = ST_DRIVE;
                ST_DRIVE: if (t_release)            state_d = ST_TERM;
                ST_TERM:  if (t_done || t_expire)   state_d = ST_IDLE;
                default:                            state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next values of the registered outputs
    always_comb begin
        en_d = port_en;
        fs_d = 1'b0;
        to_d = term_timeout;
        if (!port_power) begin
            en_d = 1'b0;
            to_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sw_wr && (sw_rst_bit || !sw_en_bit)) en_d = 1'b0;
                    if (t_start)                             to_d = 1'b0;
                end
                ST_DRIVE: en_d = 1'b0;
                ST_TERM: begin
                    if (t_done) begin
                        en_d = phy_hs;
                        fs_d = !phy_hs;
                    end
                    if (t_expire) to_d = 1'b1;
                end
                default: en_d = 1'b0;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_en      <= 1'b0;
            fs_handoff   <= 1'b0;
            term_timeout <= 1'b0;
        end else begin
            port_en      <= en_d;
            fs_handoff   <= fs_d;
            term_timeout <= to_d;
        end
    end

    assign phy_bus_rst = port_power && (state_q == ST_DRIVE);
    assign port_rst    = port_power && (state_q != ST_IDLE);

endmodule

// File: rtl/usb_port_rst_chk.sv
module usb_port_rst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_wr,
    input logic       sw_rst_bit,
    input logic       sw_en_bit,
    input logic       port_power,
    input logic       connect,
    input logic       ctl_halted,
    input logic       line_dp,
    input logic       line_dm,
    input logic       phy_hs,
    input logic       phy_rst_done,
    input logic       phy_bus_rst,
    input logic       port_rst,
    input logic       port_en,
    input logic [1:0] line_status,
    input logic       ls_valid,
    input logic       ls_handoff,
    input logic       fs_handoff,
    input logic       term_timeout
);

    // R2
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && line_dp && !line_dm) |-> (line_status == 2'b10));

    // R2
    valid_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_valid |-> (port_power && connect && !port_en));

    // R3
    ls_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_handoff |-> (ls_valid && line_status == 2'b10));

    // R4
    start_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && !port_rst && sw_wr && sw_rst_bit)
        |=> (!port_power || (port_rst && phy_bus_rst && !port_en)));

    // R5
    bus_rst_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_bus_rst |-> (port_rst && !port_en));

    // R6
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_bus_rst && ctl_halted) |=> (!port_power || phy_bus_rst));

    // R7
    hs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && port_rst && !phy_bus_rst && phy_rst_done && phy_hs)
        |=> (!port_power || (port_en && !port_rst)));

    // R8
    fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_handoff |=> !fs_handoff);

    // R8
    fs_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_handoff |-> !port_en);

    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_timeout) |-> (!port_rst && !port_en));

    // R10
    power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_power |=> (!port_en && !term_timeout));

    // R11
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && !port_rst && sw_wr && !sw_en_bit) |=> !port_en);

    // R12
    term_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && port_rst && !phy_bus_rst && !phy_rst_done && sw_wr && !ctl_halted)
        |=> (!port_power || !phy_bus_rst));

endmodule

bind usb_port_rst_ctl usb_port_rst_chk u_chk (.*);

// File: tb/usb_port_rst_ctl_bench.sv
`timescale 1ns/100ps
module usb_port_rst_ctl_bench;

    localparam int CPM   = 4;
    localparam int TMS   = 2;
    localparam int LIMIT = CPM * TMS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0, sw_rst_bit = 1'b0, sw_en_bit = 1'b0;
    logic       port_power = 1'b0, connect = 1'b0, ctl_halted = 1'b0;
    logic       line_dp = 1'b0, line_dm = 1'b0, phy_hs = 1'b0, phy_rst_done = 1'b0;
    logic       phy_bus_rst, port_rst, port_en, ls_valid, ls_handoff, fs_handoff, term_timeout;
    logic [1:0] line_status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    usb_port_rst_ctl #(.CYC_PER_MS(CPM), .TERM_MS(TMS)) u_usb_port_rst_ctl (.*);

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(input logic r, input logic e);
        sw_wr = 1'b1; sw_rst_bit = r; sw_en_bit = e;
        tick();
        sw_wr = 1'b0; sw_rst_bit = 1'b0; sw_en_bit = 1'b0;
        #0.5;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 port_en", {1'b0, port_en}, 2'b00);
        chk("R1 port_rst", {1'b0, port_rst}, 2'b00);
        chk("R1 phy_bus_rst", {1'b0, phy_bus_rst}, 2'b00);
        chk("R1 fs_handoff", {1'b0, fs_handoff}, 2'b00);
        chk("R1 term_timeout", {1'b0, term_timeout}, 2'b00);

        // R2 / R3 sweep with port disabled
        for (int i = 0; i < 16; i++) begin
            port_power = i[3]; connect = i[2]; line_dp = i[1]; line_dm = i[0];
            #0.5;
            chk("R2 line_status", line_status, i[3] ? i[1:0] : 2'b00);
            chk("R2 ls_valid", {1'b0, ls_valid}, {1'b0, i[3] & i[2]});
            chk("R3 ls_handoff", {1'b0, ls_handoff},
                {1'b0, i[3] & i[2] & (i[1:0] == 2'b10)});
        end

        // R10 write while unpowered is ignored
        port_power = 1'b0;
        sw_write(1'b1, 1'b0);
        chk("R10 unpowered write", {phy_bus_rst, port_rst}, 2'b00);

        port_power = 1'b1; connect = 1'b1; line_dp = 1'b0; line_dm = 1'b0;
        tick();

        // R11 software cannot set enable
        sw_write(1'b0, 1'b1);
        chk("R11 no set", {1'b0, port_en}, 2'b00);

        // done-delay sweep over full window, both speeds
        for (int hs = 0; hs < 2; hs++) begin
            for (int d = 0; d < LIMIT; d++) begin
                sw_write(1'b1, 1'b0);
                chk("R4 start", {port_rst, phy_bus_rst}, 2'b11);
                chk("R4 en cleared", {1'b0, port_en}, 2'b00);
                ctl_halted = 1'b1;
                sw_write(1'b0, 1'b0);
                chk("R6 halted hold", {port_rst, phy_bus_rst}, 2'b11);
                ctl_halted = 1'b0;
                sw_write(1'b0, 1'b0);
                chk("R5 release", {port_rst, phy_bus_rst}, 2'b10);
                for (int k = 0; k < d; k++) begin
                    tick();
                    chk("R5 still resetting", {port_rst, phy_bus_rst}, 2'b10);
                end
                phy_hs = hs[0]; phy_rst_done = 1'b1;
                tick();
                phy_rst_done = 1'b0;
                #0.5;
                chk(hs ? "R7 enabled" : "R8 stays disabled", {1'b0, port_en}, {1'b0, hs[0]});
                chk("R7 reset bit low", {port_rst, phy_bus_rst}, 2'b00);
                chk("R8 fs pulse", {1'b0, fs_handoff}, {1'b0, ~hs[0]});
                chk("R9 no timeout", {1'b0, term_timeout}, 2'b00);
                tick();
                chk("R8 pulse ends", {1'b0, fs_handoff}, 2'b00);
            end
        end

        // port enabled now: lines are not meaningful
        for (int i = 0; i < 4; i++) begin
            line_dp = i[1]; line_dm = i[0];
            #0.5;
            chk("R2 valid off when enabled", {1'b0, ls_valid}, 2'b00);
            chk("R3 no handoff when enabled", {1'b0, ls_handoff}, 2'b00);
            chk("R2 line_status enabled", line_status, i[1:0]);
        end
        line_dp = 1'b0; line_dm = 1'b0;

        // R11 software clears enable
        sw_write(1'b0, 1'b0);
        chk("R11 clear", {1'b0, port_en}, 2'b00);

        // R9 timeout with R12 write in the window
        sw_write(1'b1, 1'b0);
        sw_write(1'b0, 1'b0);
        sw_write(1'b1, 1'b0);
        chk("R12 ignored", {port_rst, phy_bus_rst}, 2'b10);
        for (int k = 0; k < LIMIT - 2; k++) begin
            tick();
            chk("R9 within window", {port_rst, term_timeout}, 2'b10);
        end
        tick();
        chk("R9 expired", {port_rst, term_timeout}, 2'b01);
        chk("R9 en low", {1'b0, port_en}, 2'b00);
        sw_write(1'b1, 1'b0);
        chk("R9 timeout cleared", {port_rst, term_timeout}, 2'b10);

        // R10 power off during drive
        port_power = 1'b0;
        #0.5;
        chk("R10 same cycle", {port_rst, phy_bus_rst}, 2'b00);
        tick();
        port_power = 1'b1;
        #0.5;
        chk("R10 back to idle", {port_rst, phy_bus_rst}, 2'b00);

        // R10 power off clears enable
        sw_write(1'b1, 1'b0);
        sw_write(1'b0, 1'b0);
        phy_hs = 1'b1; phy_rst_done = 1'b1;
        tick();
        phy_rst_done = 1'b0;
        chk("R7 enabled again", {1'b0, port_en}, 2'b01);
        port_power = 1'b0;
        tick();
        chk("R10 en cleared", {1'b0, port_en}, 2'b00);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule